// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that software must service inside a time window rather than merely before a deadline. Once enabled, it first counts a closed window and then an open window. The length of each window is held in its own 32-bit count register. A restart ("kick") is legal only in the open window, and it sends the counter back to the start of the closed window. A kick that arrives too early is a fault. An open window that runs out with no kick is also a fault. Either fault raises a reset request, which stays high until the block itself is reset.

Every configuration and control write is guarded by a key bit. Software sets the key before each write to the control/status register, and the key clears itself once that write has been accepted. Software stops the watchdog by clearing the enable bit. This is honoured only in the open window.

A small 32-bit register bus carries all accesses. It has an address, a write strobe, write data and combinational read data. The register offsets are: key at 0x0, control/status at 0x4, closed-window length at 0x8 and open-window length at 0xC.

Top module: `win_wdog`

## Requirements
- R1: After reset, all four registers read 0 and `rst_req` is 0.
- R2: Bit 0 of the register at 0x0 is the write key. It is written at any time and can be read back. A write to 0x4 while the key is 0 has no effect. The key returns to 0 after any accepted write to 0x4.
- R3: The count registers at 0x8 (closed length C) and 0xC (open length O) take a write only while the key is 1. Such a write does not clear the key, and the value reads back.
- R4: Register 0x4 has enable at bit 0 and the open-window flag at bit 8 (0 = closed, 1 = open). Writing bit 0 = 1 while disabled starts a closed window. Bit 8 becomes 1 max(C,1) clock edges after the edge that accepts the start write.
- R5: In the open window, a write to 0x4 with bits 8 and 0 both set is a kick. It returns the block to the closed window, and bit 8 reads 0 on the next cycle.
- R6: A write to 0x4 with bit 8 set while enabled and in the closed window sets `rst_req` at that same edge.
- R7: If no kick arrives, `rst_req` rises max(O,1) edges after the open window begins. Once high, it stays high until reset, the counter stops, and writes to 0x4 cannot clear it.
- R8: Clearing bit 0 of 0x4 disables the watchdog only in the open window; in the closed window the write is ignored and counting continues. In the open window, a write with bit 0 = 0 and bit 8 = 1 disables rather than kicks.
- R9: Bit 16 of 0x4 is set on entry to the open window and is cleared by writing 1 to it. When a clear and an entry fall on the same edge, the bit stays set.
- R10: A kick accepted on the final cycle of the open window prevents the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| rst_req | output | 1 | Sticky reset request |

## Verification
Two pairs of functions can fall on one edge. The first is a kick and the open-window expiry. The bench times the kick write so that it lands on the last open cycle, then checks that `rst_req` stays low and that the closed window begins again. The second is the entry-time setting of bit 16 and a software clear. The bench schedules a clear write for the exact edge of the closed-to-open transition and expects the flag to read 1 afterwards. Edge counts are derived from the programmed C and O alone.

// File: rtl/win_wdog.sv
module win_wdog #(
  parameter int CW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          rst_req
);

  logic          unlock, en, open_win, win_flag;
  logic [CW-1:0] len_closed, len_open, cnt;

  wire sel_key = bus_addr == AW'(0);
  wire sel_ctl = bus_addr == AW'(4);
  wire sel_cl  = bus_addr == AW'(8);
  wire sel_op  = bus_addr == AW'(12);

  wire ctl_wr    = bus_we && sel_ctl && unlock;
  wire run       = en && !rst_req;
  wire last      = cnt <= CW'(1);
  wire start     = ctl_wr && bus_wdata[0] && !en && !rst_req;
  wire do_stop   = ctl_wr && !bus_wdata[0] && run && open_win;
  wire good_kick = ctl_wr && bus_wdata[8] && bus_wdata[0] && run && open_win;
  wire bad_kick  = ctl_wr && bus_wdata[8] && run && !open_win;
  wire enter_op  = run && !open_win && last;
  wire expire    = run && open_win && last && !good_kick && !do_stop;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en       <= 1'b0;
      open_win <= 1'b0;
      cnt      <= '0;
    end else if (start) begin
      en       <= 1'b1;
      open_win <= 1'b0;
      cnt      <= len_closed;
    end else if (do_stop) begin
      en       <= 1'b0;
      open_win <= 1'b0;
      cnt      <= '0;
    end else if (good_kick) begin
      open_win <= 1'b0;
      cnt      <= len_closed;
    end else if (run) begin
      if (enter_op) begin
        open_win <= 1'b1;
        cnt      <= len_open;
      end else if (!last) begin
        cnt <= cnt - CW'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_req <= 1'b0;
    else if (bad_kick || expire) rst_req <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) win_flag <= 1'b0;
    else if (enter_op) win_flag <= 1'b1;
    else if (ctl_wr && bus_wdata[16]) win_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) unlock <= 1'b0;
    else if (bus_we && sel_key) unlock <= bus_wdata[0];
    else if (ctl_wr) unlock <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      len_closed <= '0;
      len_open   <= '0;
    end else if (bus_we && unlock) begin
      if (sel_cl) len_closed <= bus_wdata[CW-1:0];
      if (sel_op) len_open   <= bus_wdata[CW-1:0];
    end

  always_comb begin
    bus_rdata = '0;
    if (sel_key) bus_rdata = {31'b0, unlock};
    if (sel_ctl) bus_rdata = {15'b0, win_flag, 7'b0, open_win, 7'b0, en};
    if (sel_cl)  bus_rdata = 32'(len_closed);
    if (sel_op)  bus_rdata = 32'(len_open);
  end

endmodule

module win_wdog_chk #(
  parameter int CW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [31:0]   bus_wdata,
  input logic          rst_req,
  input logic          key,
  input logic          en,
  input logic          open_win,
  input logic          win_flag,
  input logic [CW-1:0] cnt
);

  wire ctl_hit = bus_we && bus_addr == AW'(4);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> $stable(cnt) && $stable(open_win));

  a_r6_early_kick: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && key && bus_wdata[8] && en && !open_win) |=> rst_req);

  a_r2_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && !key) |=> $stable(en));

  a_r2_key_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && key) |=> !key);

  a_r9_flag_on_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_win) |-> win_flag);

endmodule

bind win_wdog win_wdog_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .rst_req(rst_req), .key(unlock), .en(en),
  .open_win(open_win), .win_flag(win_flag), .cnt(cnt)
);

// File: tb/win_wdog_bench.sv
module win_wdog_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  logic [31:0] d;
  int          n_run = 0;
  int          n_bad = 0;

  localparam int NV = 4;
  localparam int VC [NV] = '{3, 1, 0, 5};
  localparam int VO [NV] = '{4, 1, 2, 1};

  win_wdog u_win_wdog (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_run++;
    n_bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    finish_up();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    bus_we = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    bus_addr = a;
    bus_wdata = v;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int c, input int o);
    wr(4'h0, 32'h1);
    wr(4'h8, 32'(c));
    wr(4'hC, 32'(o));
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h1);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), d);
      chk("R1 reg after reset", d, 32'h0);
    end
    chk("R1 rst_req after reset", {31'b0, rst_req}, 32'h0);

    // table-driven window lengths (R4, R7)
    for (int i = 0; i < NV; i++) begin
      int ce, oe;
      ce = (VC[i] == 0) ? 1 : VC[i];
      oe = (VO[i] == 0) ? 1 : VO[i];
      do_reset();
      setup(VC[i], VO[i]);
      idle(ce - 1);
      rd(4'h4, d);
      chk("R4 still closed", {31'b0, d[8]}, 32'h0);
      idle(1);
      rd(4'h4, d);
      chk("R4 open after C", {31'b0, d[8]}, 32'h1);
      idle(oe - 1);
      chk("R7 no timeout yet", {31'b0, rst_req}, 32'h0);
      idle(1);
      chk("R7 timeout after O", {31'b0, rst_req}, 32'h1);
    end

    // R2 locked write ignored, key self-clear
    do_reset();
    wr(4'h4, 32'h1);
    rd(4'h4, d);
    chk("R2 locked ctl write ignored", d, 32'h0);
    wr(4'h0, 32'h1);
    rd(4'h0, d);
    chk("R2 key reads 1", d, 32'h1);
    wr(4'h4, 32'h0);
    rd(4'h0, d);
    chk("R2 key cleared after ctl write", d, 32'h0);

    // R3 count registers gated by key, key kept
    do_reset();
    wr(4'h8, 32'd7);
    rd(4'h8, d);
    chk("R3 locked count write ignored", d, 32'h0);
    wr(4'h0, 32'h1);
    wr(4'h8, 32'd7);
    wr(4'hC, 32'hDEAD_BEEF);
    rd(4'h8, d);
    chk("R3 closed length readback", d, 32'd7);
    rd(4'hC, d);
    chk("R3 open length readback", d, 32'hDEAD_BEEF);
    rd(4'h0, d);
    chk("R3 key kept", d, 32'h1);

    // R5 kick in open reloads closed window
    do_reset();
    setup(4, 6);
    idle(4);
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h101);
    rd(4'h4, d);
    chk("R5 kick returns to closed", d[8:0], 9'h001);
    idle(3);
    rd(4'h4, d);
    chk("R5 closed window restarted", {31'b0, d[8]}, 32'h0);
    idle(1);
    rd(4'h4, d);
    chk("R5 open again after C", {31'b0, d[8]}, 32'h1);
    chk("R5 no timeout", {31'b0, rst_req}, 32'h0);

    // R6 kick in closed
    do_reset();
    setup(10, 10);
    idle(2);
    wr(4'h0, 32'h1);
    chk("R6 before early kick", {31'b0, rst_req}, 32'h0);
    wr(4'h4, 32'h101);
    chk("R6 early kick faults", {31'b0, rst_req}, 32'h1);

    // R7 sticky and frozen
    do_reset();
    setup(2, 3);
    idle(5);
    chk("R7 expired", {31'b0, rst_req}, 32'h1);
    idle(20);
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h101);
    chk("R7 sticky", {31'b0, rst_req}, 32'h1);
    rd(4'h4, d);
    chk("R7 frozen in open", d[8:0], 9'h101);

    // R8 disable rules
    do_reset();
    setup(6, 6);
    idle(1);
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h0);
    rd(4'h4, d);
    chk("R8 disable in closed ignored", {31'b0, d[0]}, 32'h1);
    idle(3);
    rd(4'h4, d);
    chk("R8 counting continued", {31'b0, d[8]}, 32'h1);
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h100);
    rd(4'h4, d);
    chk("R8 disable in open", d[8:0], 9'h000);
    idle(10);
    chk("R8 no timeout after disable", {31'b0, rst_req}, 32'h0);

    // R9 flag set, clear, and same-edge collision
    do_reset();
    setup(3, 20);
    idle(3);
    rd(4'h4, d);
    chk("R9 flag set on open", {31'b0, d[16]}, 32'h1);
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h10001);
    rd(4'h4, d);
    chk("R9 flag cleared", d, 32'h101);
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h101);
    idle(1);
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h10001);
    rd(4'h4, d);
    chk("R9 set wins over clear", d, 32'h10101);

    // R10 kick on final open cycle
    do_reset();
    setup(3, 4);
    idle(3 + 4 - 2);
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h101);
    chk("R10 last-cycle kick avoids timeout", {31'b0, rst_req}, 32'h0);
    rd(4'h4, d);
    chk("R10 back in closed", d[8:0], 9'h001);
    idle(3);
    rd(4'h4, d);
    chk("R10 open after restart", {31'b0, d[8]}, 32'h1);
    chk("R10 still no fault", {31'b0, rst_req}, 32'h0);

    finish_up();
  end
endmodule